// File: doc/BRIEF.md
# Programmable Divide-by-N Counter

This block divides its clock by a ratio chosen on a 6-bit value input. Inside it is a universal presettable counter with a registered, active-low terminal-count flag. That flag is fed back into the counter's mode selection. While the flag is high the counter counts. In the cycle the flag is low, the next clock edge loads the counter with the preset value. Loading itself takes one clock edge, so dividing by N needs N−1 on the preset input in the default down-counting variant. Ratios from 2 to 64 are reachable.

The divided clock is the flag itself. It is low for one cycle out of every N. A complementary copy is also provided, so the consumer can pick a high-going or a low-going pulse. A parameter selects an up-counting variant instead. In that variant the feedback steers the other mode select line, the counter climbs to all ones, and the preset for ratio N is 2^WIDTH − N. An asynchronous active-low reset clears the count and sets the flag high. The first period after reset is therefore a full wrap from zero and is not part of the programmed ratio.

Top module: `prog_divider`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `div_out_n` is 1 and `div_out` is 0, regardless of the clock.
- R2: In the down variant (COUNT_UP=0), with `preset` = V for V in 1..63 presented at each reload, the spacing between successive low cycles of `div_out_n` is V+1 clocks. `div_out_n` is low for exactly one cycle of each period.
- R3: In the down variant, `count` takes the value `preset` on the edge after a low `div_out_n`, then decreases by one per clock down to 0. With V=36 the sequence is 36, 35, …, 1, 0, 36.
- R4: `div_out_n` goes low only in the cycle after the counter has counted into its terminal value (0 when down, all ones when up). Loading the terminal value does not pulse the flag. With `preset` = 0 in the down variant, the period is 2^WIDTH + 1 = 65.
- R5: `div_out` is always the complement of `div_out_n`.
- R6: After reset is released, the first low cycle of `div_out_n` comes 2^WIDTH = 64 clocks later, because the counter wraps down from 0.
- R7: `preset` is sampled only on the reload edge. A change during a period affects only the next period. A change made in the same cycle that `div_out_n` is low is used by the reload that follows it.
- R8: In the up variant (COUNT_UP=1), with `preset` = D for D in 0..62, the period is 2^WIDTH − D clocks, and `count` rises by one per clock from D to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | WIDTH | Reload value (N−1 for down, 2^WIDTH−N for up) |
| count | output | WIDTH | Current counter value |
| div_out_n | output | 1 | Divided output, low one cycle per period |
| div_out | output | 1 | Complement of div_out_n |

## Verification
The terminal-count pulse and the reload of a new ratio fall on the same edge, because the low flag is what selects the load. The bench provokes this by changing `preset` in the very cycle the pulse is low, and by changing it in the middle of a period. A behavioural model predicts the count and the flag on every clock. The model is compared with the design, and the measured periods are compared with V+1, or with 2^WIDTH−D for the up variant.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
   // Mode select encoding {sel_hi, sel_lo}
   typedef enum logic [1:0] {
      SEL_LOAD = 2'b00,
      SEL_DOWN = 2'b01,
      SEL_UP   = 2'b10,
      SEL_HOLD = 2'b11
   } sel_e;
endpackage

// File: rtl/pdiv_steer.sv
module pdiv_steer #(
   parameter bit COUNT_UP = 1'b0
) (
   input  logic            carry_n,
   output pdiv_pkg::sel_e  sel
);
   generate
      if (COUNT_UP) begin : g_up
         // low select line tied, flag drives high select line
         assign sel = pdiv_pkg::sel_e'({carry_n, 1'b0});
      end else begin : g_down
         // high select line tied low, flag drives low select line
         assign sel = pdiv_pkg::sel_e'({1'b0, carry_n});
      end
   endgenerate
endmodule

// File: rtl/pdiv_next.sv
module pdiv_next #(
   parameter int WIDTH = 6
) (
   input  pdiv_pkg::sel_e     sel,
   input  logic [WIDTH-1:0]   q,
   input  logic [WIDTH-1:0]   preset,
   output logic [WIDTH-1:0]   q_nxt,
   output logic               carry_n_nxt
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;
   localparam logic [WIDTH-1:0] ZERO     = '0;
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

   always_comb begin
      q_nxt       = q;
      carry_n_nxt = 1'b1;
      unique case (sel)
         pdiv_pkg::SEL_LOAD: begin
            q_nxt       = preset;
            carry_n_nxt = 1'b1;  // a loaded terminal value never pulses
         end
         pdiv_pkg::SEL_UP: begin
            q_nxt       = q + ONE;
            carry_n_nxt = ~(q_nxt == ALL_ONES);
         end
         pdiv_pkg::SEL_DOWN: begin
            q_nxt       = q - ONE;
            carry_n_nxt = ~(q_nxt == ZERO);
         end
         default: begin
            q_nxt       = q;
            carry_n_nxt = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/pdiv_regs.sv
module pdiv_regs #(
   parameter int WIDTH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  q_nxt,
   input  logic              carry_n_nxt,
   output logic [WIDTH-1:0]  q,
   output logic              carry_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '0;
         carry_n <= 1'b1;
      end else begin
         q       <= q_nxt;
         carry_n <= carry_n_nxt;
      end
   end

   // carry flag is a single-cycle pulse
   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |=> carry_n);
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
   parameter int WIDTH    = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  preset,
   output logic [WIDTH-1:0]  count,
   output logic              div_out_n,
   output logic              div_out
);
   localparam logic [WIDTH-1:0] TERM = COUNT_UP ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
         $error("prog_divider: WIDTH out of range");
      end
   endgenerate

   pdiv_pkg::sel_e    sel;
   logic [WIDTH-1:0]  q_nxt;
   logic              carry_n_nxt;
   logic              carry_n;

   pdiv_steer #(.COUNT_UP(COUNT_UP)) u_steer (
      .carry_n (carry_n),
      .sel     (sel)
   );

   pdiv_next #(.WIDTH(WIDTH)) u_next (
      .sel         (sel),
      .q           (count),
      .preset      (preset),
      .q_nxt       (q_nxt),
      .carry_n_nxt (carry_n_nxt)
   );

   pdiv_regs #(.WIDTH(WIDTH)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .q_nxt       (q_nxt),
      .carry_n_nxt (carry_n_nxt),
      .q           (count),
      .carry_n     (carry_n)
   );

   assign div_out_n = carry_n;
   assign div_out   = ~carry_n;

   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (count == '0 && div_out_n));

   assert_pulse_at_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !div_out_n |-> count == TERM);

   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !div_out_n |=> count == $past(preset));

   assert_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_out != div_out_n);

   generate
      if (COUNT_UP) begin : g_chk_up
         assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
            div_out_n |=> count == $past(count) + ONE);
      end else begin : g_chk_down
         assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
            div_out_n |=> count == $past(count) - ONE);
      end
   endgenerate
endmodule

// File: tb/prog_divider_bench.sv
module prog_divider_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 6;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] dn_val = '0;
   logic [W-1:0] up_val = '0;
   logic [W-1:0] dn_count, up_count;
   logic dn_out_n, dn_out, up_out_n, up_out;

   integer checks = 0;
   integer failures = 0;
   bit cmp_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_divider #(.WIDTH(W), .COUNT_UP(1'b0)) u_prog_divider (
      .clk(clk), .rst_n(rst_n), .preset(dn_val),
      .count(dn_count), .div_out_n(dn_out_n), .div_out(dn_out));

   prog_divider #(.WIDTH(W), .COUNT_UP(1'b1)) u_prog_divider_up (
      .clk(clk), .rst_n(rst_n), .preset(up_val),
      .count(up_count), .div_out_n(up_out_n), .div_out(up_out));

   // behavioural reference
   integer m_q, m_n, mu_q, mu_n;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= 0; m_n <= 1; mu_q <= 0; mu_n <= 1;
      end else begin
         if (m_n == 0) begin
            m_q <= dn_val; m_n <= 1;
         end else begin
            m_q <= (m_q == 0) ? MAXV : m_q - 1;
            m_n <= (m_q == 1) ? 0 : 1;
         end
         if (mu_n == 0) begin
            mu_q <= up_val; mu_n <= 1;
         end else begin
            mu_q <= (mu_q == MAXV) ? 0 : mu_q + 1;
            mu_n <= (mu_q == MAXV - 1) ? 0 : 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input integer act, input integer exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(dn_count == m_q, "R3 down count", dn_count, m_q);
         chk(dn_out_n == m_n, "R4 down flag", dn_out_n, m_n);
         chk(dn_out == ~dn_out_n, "R5 down polarity", dn_out, ~dn_out_n);
         chk(up_count == mu_q, "R8 up count", up_count, mu_q);
         chk(up_out_n == mu_n, "R8 up flag", up_out_n, mu_n);
         chk(up_out == ~up_out_n, "R5 up polarity", up_out, ~up_out_n);
      end
   end

   task automatic wait_dn_pulse();
      do @(negedge clk); while (dn_out_n !== 1'b0);
   endtask

   task automatic wait_up_pulse();
      do @(negedge clk); while (up_out_n !== 1'b0);
   endtask

   // counts clocks from the current pulse to the next one
   task automatic dn_period(output integer n);
      n = 0;
      do begin @(negedge clk); n = n + 1; end while (dn_out_n !== 1'b0);
   endtask

   task automatic up_period(output integer n);
      n = 0;
      do begin @(negedge clk); n = n + 1; end while (up_out_n !== 1'b0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      integer n;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dn_count == 0 && dn_out_n == 1 && dn_out == 0, "R1 reset down",
          {dn_count, dn_out_n, dn_out}, 2);
      chk(up_count == 0 && up_out_n == 1 && up_out == 0, "R1 reset up",
          {up_count, up_out_n, up_out}, 2);
      cmp_en = 1'b1;
      #1 rst_n = 1'b1;

      // R6: first pulse after release is a full wrap
      dn_period(n);
      chk(n == MAXV + 1, "R6 first pulse", n, MAXV + 1);

      // R2: period sweep, new value set in the pulse cycle (R7 coincidence)
      for (int v = 1; v <= MAXV; v++) begin
         #1 dn_val = W'(v);
         dn_period(n);
         chk(n == v + 1, "R2 period", n, v + 1);
      end

      // R3: divide by 37 sequence
      #1 dn_val = 6'd36;
      for (int k = 36; k >= 0; k--) begin
         @(negedge clk);
         chk(dn_count == k, "R3 sequence", dn_count, k);
      end
      @(negedge clk);
      chk(dn_count == 36, "R3 reload", dn_count, 36);

      // R4: loading zero does not pulse; period 65
      wait_dn_pulse();
      #1 dn_val = 6'd0;
      @(negedge clk);
      chk(dn_count == 0 && dn_out_n == 1, "R4 loaded terminal no pulse",
          {dn_count, dn_out_n}, 1);
      n = 1;
      do begin @(negedge clk); n = n + 1; end while (dn_out_n !== 1'b0);
      chk(n == MAXV + 2, "R4 zero preset period", n, MAXV + 2);

      // R7: mid-period change affects only the next period
      #1 dn_val = 6'd20;
      n = 0;
      repeat (3) begin @(negedge clk); n = n + 1; end
      #1 dn_val = 6'd9;
      do begin @(negedge clk); n = n + 1; end while (dn_out_n !== 1'b0);
      chk(n == 21, "R7 current period kept", n, 21);
      dn_period(n);
      chk(n == 10, "R7 next period uses new value", n, 10);

      // R8: up variant periods
      for (int d = 0; d <= MAXV - 1; d += 7) begin
         wait_up_pulse();
         #1 up_val = W'(d);
         up_period(n);
         chk(n == MAXV + 1 - d, "R8 up period", n, MAXV + 1 - d);
      end
      wait_up_pulse();
      #1 up_val = W'(MAXV - 1);
      up_period(n);
      chk(n == 2, "R8 up divide by two", n, 2);

      // R1: asynchronous reset mid-count
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b0;
      #2;
      chk(dn_count == 0 && dn_out_n == 1 && dn_out == 0, "R1 async reset",
          {dn_count, dn_out_n, dn_out}, 2);
      chk(up_count == 0 && up_out_n == 1, "R1 async reset up",
          {up_count, up_out_n}, 1);
      @(negedge clk);
      #1 rst_n = 1'b1;
      dn_period(n);
      chk(n == MAXV + 1, "R6 first pulse after second reset", n, MAXV + 1);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule